// File: doc/BRIEF.md
# Synchronous Exception Entry and Return Sequencer

This block sits beside a 32-bit processor's issue stage and owns the processor status word (PSW). It handles two synchronous exceptions and the matching return. A decoded software-interrupt instruction enters supervisor mode. An instruction the core cannot execute is first offered to the coprocessors, and only if none accepts it does the block take the undefined-instruction trap into undefined mode. On entry, in one clock cycle, it writes the target mode's banked link value (the instruction address plus 4), saves the PSW into that mode's banked copy, switches the mode field, masks interrupts, redirects fetch to the mode's vector and raises a pipeline flush.

When a coprocessor accepts the instruction but reports busy, the block stalls issue and waits. The wait ends in one of two ways. If busy clears, the instruction retires. If an interrupt arrives first, control passes to the interrupt entry path and the instruction is left unretired, so it is offered again later. The return operation reloads the program counter from the current mode's link value and the PSW from the current mode's saved copy.

The sequencer has two states: `ST_IDLE` and `ST_CPWAIT`. In `ST_IDLE`, a coprocessor acceptance with busy moves it to `ST_CPWAIT`. Every other event is handled within `ST_IDLE`, and the block stays there. In `ST_CPWAIT`, busy clearing returns the block to `ST_IDLE` with a retire. An interrupt while still busy returns it to `ST_IDLE` with an interrupt hand-off. Otherwise the block stays in `ST_CPWAIT` and holds the stall.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the PSW reads 0x0000_0093 (mode field bits [4:0] = 10011 supervisor, interrupt-mask bit 7 set), and `pc_load`, `flush`, `stall`, `cp_retire` and `irq_take` are low.
- R2: A valid instruction with `swi_req` high, `unhandled` low and the block idle writes `cur_pc`+4 into the supervisor link bank and the pre-entry PSW into the supervisor saved bank.
- R3: In that same cycle `pc_load` and `flush` are high and `pc_target` is 0x08. From the next cycle the PSW has bits [4:0] = 10011 and bit 7 set, with all other bits unchanged.
- R4: A valid `unhandled` instruction with `cp_accept` low writes `cur_pc`+4 into the undefined-mode link bank and the pre-entry PSW into the undefined-mode saved bank.
- R5: In that same cycle `pc_load` and `flush` are high and `pc_target` is 0x04. From the next cycle the PSW has bits [4:0] = 11011 and bit 7 set, with all other bits unchanged.
- R6: A valid `unhandled` instruction with `cp_accept` high and `cp_busy` low raises `cp_retire` in that cycle. No trap is taken and the PSW is unchanged.
- R7: A valid `unhandled` instruction with `cp_accept` and `cp_busy` high raises `stall` and enters the wait. `stall` stays high while busy persists and `irq` is low. The cycle in which busy drops raises `cp_retire`, with `stall` low and no trap.
- R8: During the wait, `irq` high while still busy raises `irq_take` and ends the wait, with no retire, no trap and no PSW change. If busy drops in the same cycle, the retire wins.
- R9: `exc_return` with no valid instruction in supervisor or undefined mode raises `pc_load` and `flush`, drives `pc_target` from that mode's link bank, and loads the PSW from that mode's saved bank on the next edge.
- R10: A return in any other mode is ignored: `pc_load` and `flush` stay low and the PSW is unchanged.
- R11: When `unhandled` and `swi_req` are both high on a valid instruction, the undefined path is taken, not the software interrupt.
- R12: `psw_wr_en` loads `psw_wr_data` into the PSW when no entry or return occurs that cycle. An entry or return in the same cycle takes precedence and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented at issue |
| swi_req | input | 1 | Decoder flags the instruction as a software interrupt |
| unhandled | input | 1 | Core cannot execute the instruction itself |
| cur_pc | input | 32 | Address of the presented instruction |
| cp_accept | input | 1 | A coprocessor claims the instruction |
| cp_busy | input | 1 | The claiming coprocessor is not ready yet |
| irq | input | 1 | Interrupt request, already masked by the caller |
| exc_return | input | 1 | Exception-return operation requested |
| psw_wr_en | input | 1 | Datapath write of the PSW |
| psw_wr_data | input | 32 | Value for the datapath PSW write |
| psw | output | 32 | Current processor status word |
| pc_load | output | 1 | Fetch redirect this cycle |
| pc_target | output | 32 | Redirect address |
| flush | output | 1 | Pipeline flush, coincident with the redirect |
| stall | output | 1 | Hold issue while a coprocessor is busy |
| cp_retire | output | 1 | Coprocessor completed the instruction |
| irq_take | output | 1 | Busy wait abandoned in favour of the interrupt |

## Verification
The bench goes after the coprocessor handshake corners. These are an acceptance with busy that lasts several cycles, busy clearing in the same cycle that an interrupt arrives, and an interrupt that cuts the wait short. A design that let the interrupt win the tie would lose a completed instruction. A design that trapped or retired on an interrupt exit would corrupt the banks or execute the instruction twice. The bench also checks a return issued in a mode with no bank, which a careless decoder would turn into a jump to a stale link value. It checks an instruction flagged both unhandled and software interrupt, where the wrong priority writes the supervisor bank. It checks a datapath status write that collides with an entry, which would lose the saved value or the new mode.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int PSW_W    = 32;
    localparam int MODE_W   = 5;
    localparam int IMASK    = 7;
    localparam int NBANK    = 2;
    localparam int BANK_IW  = $clog2(NBANK);

    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    localparam logic [PSW_W-1:0] VEC_SWI   = 32'h0000_0008;
    localparam logic [PSW_W-1:0] VEC_UND   = 32'h0000_0004;
    localparam logic [PSW_W-1:0] PSW_RESET = 32'h0000_0093;

    localparam logic [BANK_IW-1:0] BANK_SVC = 1'b0;
    localparam logic [BANK_IW-1:0] BANK_UND = 1'b1;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_CPWAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic take_swi;
        logic take_und;
        logic take_ret;
    } exc_evt_t;

    function automatic logic mode_has_bank(input logic [MODE_W-1:0] m);
        return (m == MODE_SVC) || (m == MODE_UND);
    endfunction

    function automatic logic [BANK_IW-1:0] mode_to_bank(input logic [MODE_W-1:0] m);
        return (m == MODE_UND) ? BANK_UND : BANK_SVC;
    endfunction

    function automatic logic [PSW_W-1:0] enter_psw(input logic [PSW_W-1:0] p,
                                                   input logic [MODE_W-1:0] m);
        logic [PSW_W-1:0] r;
        r = p;
        r[IMASK] = 1'b1;
        r[MODE_W-1:0] = m;
        return r;
    endfunction
endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     instr_valid,
    input  logic     swi_req,
    input  logic     unhandled,
    input  logic     cp_accept,
    input  logic     cp_busy,
    input  logic     irq,
    input  logic     exc_return,
    input  logic     ret_ok,
    output exc_evt_t evt,
    output logic     cp_retire,
    output logic     irq_take,
    output logic     stall
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        evt       = '0;
        cp_retire = 1'b0;
        irq_take  = 1'b0;
        stall     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid && unhandled) begin
                    if (!cp_accept) begin
                        evt.take_und = 1'b1;
                    end else if (!cp_busy) begin
                        cp_retire = 1'b1;
                    end else begin
                        stall   = 1'b1;
                        state_d = ST_CPWAIT;
                    end
                end else if (instr_valid && swi_req) begin
                    evt.take_swi = 1'b1;
                end else if (!instr_valid && exc_return && ret_ok) begin
                    evt.take_ret = 1'b1;
                end
            end
            ST_CPWAIT: begin
                if (!cp_busy) begin
                    cp_retire = 1'b1;
                    state_d   = ST_IDLE;
                end else if (irq) begin
                    irq_take = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    stall = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R6 / R8: at most one outcome per cycle
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.take_swi, evt.take_und, evt.take_ret, cp_retire, irq_take}));

    // R8: interrupt hand-off leaves the wait
    a_r8_irq_exits_wait: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (state_q == ST_IDLE));

    // R7: a busy wait without interrupt keeps waiting
    a_r7_busy_keeps_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CPWAIT && cp_busy && !irq) |=> (state_q == ST_CPWAIT));
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
    import exc_pkg::*;
#(
    parameter int W     = PSW_W,
    parameter int BANKS = NBANK,
    localparam int IW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_sel,
    input  logic [W-1:0]  wr_link,
    input  logic [W-1:0]  wr_saved,
    input  logic [IW-1:0] rd_sel,
    output logic [W-1:0]  rd_link,
    output logic [W-1:0]  rd_saved
);
    logic [W-1:0] link_q  [BANKS];
    logic [W-1:0] saved_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                link_q[b]  <= '0;
                saved_q[b] <= '0;
            end else if (wr_en && wr_sel == IW'(b)) begin
                link_q[b]  <= wr_link;
                saved_q[b] <= wr_saved;
            end
        end
    end

    assign rd_link  = link_q[rd_sel];
    assign rd_saved = saved_q[rd_sel];
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  exc_evt_t         evt,
    input  logic [PSW_W-1:0] ret_psw,
    input  logic             wr_en,
    input  logic [PSW_W-1:0] wr_data,
    output logic [PSW_W-1:0] psw
);
    logic [PSW_W-1:0] psw_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            psw_q <= PSW_RESET;
        else if (evt.take_und) psw_q <= enter_psw(psw_q, MODE_UND);
        else if (evt.take_swi) psw_q <= enter_psw(psw_q, MODE_SVC);
        else if (evt.take_ret) psw_q <= ret_psw;
        else if (wr_en)        psw_q <= wr_data;
    end

    assign psw = psw_q;

    // R12: nothing moves the PSW without a cause
    a_r12_psw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.take_swi || evt.take_und || evt.take_ret || wr_en) |=> $stable(psw_q));

    // R3: supervisor entry sets mode and mask
    a_r3_swi_mode: assert property (@(posedge clk) disable iff (!rst_n)
        evt.take_swi |=> (psw_q[MODE_W-1:0] == MODE_SVC) && psw_q[IMASK]);

    // R5: undefined entry sets mode and mask
    a_r5_und_mode: assert property (@(posedge clk) disable iff (!rst_n)
        evt.take_und |=> (psw_q[MODE_W-1:0] == MODE_UND) && psw_q[IMASK]);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = PSW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic            swi_req,
    input  logic            unhandled,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            cp_accept,
    input  logic            cp_busy,
    input  logic            irq,
    input  logic            exc_return,
    input  logic            psw_wr_en,
    input  logic [XLEN-1:0] psw_wr_data,
    output logic [XLEN-1:0] psw,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            flush,
    output logic            stall,
    output logic            cp_retire,
    output logic            irq_take
);
    localparam logic [XLEN-1:0] LINK_OFS = XLEN'(4);

    exc_evt_t          evt;
    logic              ret_ok;
    logic [BANK_IW-1:0] wr_sel, rd_sel;
    logic [XLEN-1:0]   rd_link, rd_saved;

    assign ret_ok = mode_has_bank(psw[MODE_W-1:0]);
    assign rd_sel = mode_to_bank(psw[MODE_W-1:0]);
    assign wr_sel = evt.take_und ? BANK_UND : BANK_SVC;

    exc_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .swi_req     (swi_req),
        .unhandled   (unhandled),
        .cp_accept   (cp_accept),
        .cp_busy     (cp_busy),
        .irq         (irq),
        .exc_return  (exc_return),
        .ret_ok      (ret_ok),
        .evt         (evt),
        .cp_retire   (cp_retire),
        .irq_take    (irq_take),
        .stall       (stall)
    );

    exc_bank_file #(.W(XLEN), .BANKS(NBANK)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (evt.take_swi || evt.take_und),
        .wr_sel   (wr_sel),
        .wr_link  (cur_pc + LINK_OFS),
        .wr_saved (psw),
        .rd_sel   (rd_sel),
        .rd_link  (rd_link),
        .rd_saved (rd_saved)
    );

    exc_status_reg u_psw (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .ret_psw (rd_saved),
        .wr_en   (psw_wr_en),
        .wr_data (psw_wr_data),
        .psw     (psw)
    );

    always_comb begin
        pc_load   = evt.take_swi || evt.take_und || evt.take_ret;
        flush     = pc_load;
        if (evt.take_und)      pc_target = VEC_UND;
        else if (evt.take_swi) pc_target = VEC_SWI;
        else                   pc_target = rd_link;
    end

    // R4: undefined entry leaves the faulting address plus 4 in the bank
    a_r4_und_link: assert property (@(posedge clk) disable iff (!rst_n)
        evt.take_und |=> (rd_link == $past(cur_pc) + LINK_OFS));

    // R2: supervisor entry saves the pre-entry PSW
    a_r2_swi_saved: assert property (@(posedge clk) disable iff (!rst_n)
        evt.take_swi |=> (rd_saved == $past(psw)));

    // R9: return restores the saved PSW of the mode it left
    a_r9_ret_restore: assert property (@(posedge clk) disable iff (!rst_n)
        evt.take_ret |=> (psw == $past(rd_saved)));

    // R7: no redirect while stalled
    a_r7_no_load_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !pc_load);
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid, swi_req, unhandled, cp_accept, cp_busy, irq, exc_return, psw_wr_en;
    logic [31:0] cur_pc, psw_wr_data;
    logic [31:0] psw, pc_target;
    logic        pc_load, flush, stall, cp_retire, irq_take;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_psw;
    logic [31:0] m_link [2];
    logic [31:0] m_saved[2];

    always #4 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .swi_req(swi_req),
        .unhandled(unhandled), .cur_pc(cur_pc), .cp_accept(cp_accept), .cp_busy(cp_busy),
        .irq(irq), .exc_return(exc_return), .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .psw(psw), .pc_load(pc_load), .pc_target(pc_target), .flush(flush), .stall(stall),
        .cp_retire(cp_retire), .irq_take(irq_take)
    );

    function automatic logic [31:0] entered(input logic [31:0] p, input logic [4:0] m);
        logic [31:0] r;
        r = p; r[7] = 1'b1; r[4:0] = m;
        return r;
    endfunction

    function automatic int bank_of(input logic [31:0] p);
        if (p[4:0] == 5'b10011) return 0;
        if (p[4:0] == 5'b11011) return 1;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%08h exp=%08h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic quiet();
        instr_valid = 0; swi_req = 0; unhandled = 0; cp_accept = 0; cp_busy = 0;
        irq = 0; exc_return = 0; psw_wr_en = 0; cur_pc = '0; psw_wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // Entry: software interrupt, or undefined when und=1 (R11 when both)
    task automatic do_entry(input logic [31:0] pc, input bit und, input bit swi, input bit wr);
        int b;
        instr_valid = 1; unhandled = und; swi_req = swi; cur_pc = pc;
        psw_wr_en = wr; psw_wr_data = 32'hA5A5_0010;
        #1;
        chk(und ? "R5 pc_load" : "R3 pc_load", {31'b0, pc_load}, 32'd1);
        chk(und ? "R5 flush" : "R3 flush", {31'b0, flush}, 32'd1);
        chk(und ? (swi ? "R11 vector" : "R5 vector") : "R3 vector", pc_target, und ? 32'h4 : 32'h8);
        step(); quiet();
        b = und ? 1 : 0;
        m_link[b] = pc + 4; m_saved[b] = m_psw;
        m_psw = entered(m_psw, und ? 5'b11011 : 5'b10011);
        chk(wr ? "R12 entry wins" : (und ? "R5 psw" : "R3 psw"), psw, m_psw);
    endtask

    // Return checks link (R2/R4) and saved (R2/R4/R9) or ignore (R10)
    task automatic do_return();
        int b;
        b = bank_of(m_psw);
        exc_return = 1;
        #1;
        if (b < 0) begin
            chk("R10 no load", {31'b0, pc_load}, 32'd0);
            chk("R10 no flush", {31'b0, flush}, 32'd0);
        end else begin
            chk("R9 pc_load", {31'b0, pc_load}, 32'd1);
            chk(b == 1 ? "R4 link via R9" : "R2 link via R9", pc_target, m_link[b]);
        end
        step(); quiet();
        if (b >= 0) m_psw = m_saved[b];
        chk(b < 0 ? "R10 psw kept" : "R9 psw restored", psw, m_psw);
    endtask

    task automatic do_write(input logic [31:0] v);
        psw_wr_en = 1; psw_wr_data = v;
        step(); quiet();
        m_psw = v;
        chk("R12 write", psw, m_psw);
    endtask

    // Coprocessor path: k busy cycles, then end by busy drop (tie = irq too) or irq
    task automatic do_cp(input logic [31:0] pc, input int k, input bit by_irq, input bit tie);
        instr_valid = 1; unhandled = 1; cp_accept = 1; cp_busy = (k > 0); cur_pc = pc;
        #1;
        chk("R6 no trap", {31'b0, pc_load}, 32'd0);
        if (k == 0) begin
            chk("R6 retire", {31'b0, cp_retire}, 32'd1);
            chk("R6 no stall", {31'b0, stall}, 32'd0);
        end else begin
            chk("R7 stall", {31'b0, stall}, 32'd1);
            step();
            for (int i = 1; i < k; i++) begin
                #1; chk("R7 stall held", {31'b0, stall}, 32'd1);
                chk("R7 no retire", {31'b0, cp_retire}, 32'd0);
                step();
            end
            if (by_irq) begin
                irq = 1;
                #1;
                chk("R8 irq_take", {31'b0, irq_take}, 32'd1);
                chk("R8 no retire", {31'b0, cp_retire}, 32'd0);
                chk("R8 no stall", {31'b0, stall}, 32'd0);
                chk("R8 no trap", {31'b0, pc_load}, 32'd0);
            end else begin
                cp_busy = 0; irq = tie;
                #1;
                chk(tie ? "R8 tie retire" : "R7 retire", {31'b0, cp_retire}, 32'd1);
                chk(tie ? "R8 tie no irq" : "R7 no irq", {31'b0, irq_take}, 32'd0);
                chk("R7 no stall", {31'b0, stall}, 32'd0);
                chk("R7 no trap", {31'b0, pc_load}, 32'd0);
            end
        end
        step(); quiet();
        chk(k == 0 ? "R6 psw kept" : "R8 psw kept", psw, m_psw);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed, op;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        quiet();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        m_psw = 32'h93; m_link[0] = 0; m_link[1] = 0; m_saved[0] = 0; m_saved[1] = 0;

        #1;
        chk("R1 psw", psw, 32'h0000_0093);
        chk("R1 outs", {27'b0, pc_load, flush, stall, cp_retire, irq_take}, 32'd0);

        do_write(32'h2000_0010);
        do_entry(32'h0000_1000, 0, 1, 0);
        do_return();
        do_entry(32'h0000_2200, 1, 0, 0);
        do_return();
        do_return();
        do_write(32'h0000_001F);
        do_entry(32'h0000_3300, 1, 1, 0);
        do_entry(32'h0000_4400, 0, 1, 1);
        do_return();
        do_return();
        do_cp(32'h0000_5000, 0, 0, 0);
        do_cp(32'h0000_5004, 3, 0, 0);
        do_cp(32'h0000_5008, 2, 1, 0);
        do_cp(32'h0000_500C, 4, 0, 1);
        do_cp(32'h0000_5010, 1, 1, 0);

        for (int n = 0; n < 300; n++) begin
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin
                    logic [31:0] v;
                    v = $urandom;
                    case ($urandom_range(0, 2))
                        0: v[4:0] = 5'b10011;
                        1: v[4:0] = 5'b11011;
                        default: v[4:0] = 5'b10000;
                    endcase
                    do_write(v);
                end
                1: do_entry({$urandom} & 32'hFFFF_FFFC, 0, 1, $urandom_range(0, 1));
                2: do_entry({$urandom} & 32'hFFFF_FFFC, 1, $urandom_range(0, 1), $urandom_range(0, 1));
                3: do_return();
                4: do_cp({$urandom} & 32'hFFFF_FFFC, $urandom_range(0, 5),
                         $urandom_range(0, 1), $urandom_range(0, 1));
                default: begin
                    do_entry({$urandom} & 32'hFFFF_FFFC, $urandom_range(0, 1), 1, 0);
                    do_return();
                end
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule